// File: doc/BRIEF.md
# Fractional-Rate Channel Level Averager

This block turns five per-clock channel levels (two pulse, one triangle, one noise, one delta) into averaged samples at a lower audio rate. On every cycle that carries valid input, the levels that are not muted are added into four running sums. The two pulse levels share one sum; triangle, noise and delta each have their own. A count of the cycles in the current window is kept alongside the sums.

Sample boundaries come from a 32-bit fractional phase accumulator. Each valid cycle adds a programmable increment to the phase. When the phase overflows, the block emits an output sample. Each field of that sample is the integer average of its group over the window that just ended. The sums and the cycle count then restart from zero.

The increment is 2^32 times the output rate divided by the input rate. It comes out of reset at the value for 44100 Hz output from a 1789773 Hz input clock. Software can load a new increment, and doing so restarts the whole window. The output is a registered valid/ready pair.

Top module: `audio_decim`

## Requirements
- R1: After reset, out_valid is low, the phase, sums and cycle count are zero, and the increment equals floor(2^32 * OUT_RATE / IN_RATE), which is 44100 and 1789773 by default.
- R2: On each cycle with in_valid high and inc_load low, the increment is added to the 32-bit phase. When the unbounded sum reaches 2^32 or more, the phase keeps the low 32 bits and a sample is emitted, visible on the outputs one clock later.
- R3: The pulse group sum adds lvl_p1 + lvl_p2. The triangle, noise and delta groups each add their own level. The levels of the emitting cycle are part of that sample's window.
- R4: Each emitted field is floor(group sum / N), where N is the number of cycles counted in the window, including the emitting cycle.
- R5: After an emission, every sum and the cycle count start again from zero.
- R6: Setting mute bit 0 replaces pulse 1 with zero before it is summed. Bit 1 does the same for pulse 2, bit 2 for triangle, bit 3 for noise and bit 4 for delta.
- R7: A cycle with in_valid low adds nothing to the sums or the count and leaves the phase unchanged.
- R8: A cycle with inc_load high has these effects: the increment takes inc_value, the phase, sums and count are cleared, and out_valid is low on the next cycle. Its in_valid and levels are ignored.
- R9: The cycle count saturates at 2^CNT_W-1. After that, further valid cycles in the window are neither counted nor summed, but the phase still advances.
- R10: While out_valid is high and out_ready is low, the output fields hold steady. A sample emitted during that time is discarded, but its window still restarts.
- R11: When out_ready is high and no new sample is emitted, out_valid drops on the next cycle. A sample emitted in a cycle where the held one is accepted replaces it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Levels on this cycle are to be accumulated |
| lvl_p1 | input | LVL_W | Pulse 1 level |
| lvl_p2 | input | LVL_W | Pulse 2 level |
| lvl_tri | input | LVL_W | Triangle level |
| lvl_noise | input | LVL_W | Noise level |
| lvl_delta | input | LVL_W | Delta level |
| mute | input | 5 | Per-channel mute (bit 0 p1, 1 p2, 2 tri, 3 noise, 4 delta) |
| inc_load | input | 1 | Load a new increment and restart the window |
| inc_value | input | PH_W | Increment loaded by inc_load |
| out_valid | output | 1 | An averaged sample is held |
| out_ready | input | 1 | Consumer accepts the held sample |
| avg_pulse | output | LVL_W+1 | Average of the pulse group sum |
| avg_tri | output | LVL_W | Average triangle level |
| avg_noise | output | LVL_W | Average noise level |
| avg_delta | output | LVL_W | Average delta level |

## Verification
An emission is decided at the clock edge where the phase overflows. The averaged sample therefore appears on the outputs one cycle after the levels of that edge are applied. A load or a handshake shows its effect on out_valid after the same single edge. The bench drives inputs at the falling edge and steps a behavioural model through the same edge. At the following falling edge it compares out_valid and every output field against the model, so each result is checked in the exact cycle it falls due. Stall-time drops, windows restarted by a load, and saturated windows are all covered by the same per-cycle comparison.

// File: rtl/decim_pkg.sv
package decim_pkg;
   localparam int NUM_CH   = 5;
   localparam int CH_P1    = 0;
   localparam int CH_P2    = 1;
   localparam int CH_TRI   = 2;
   localparam int CH_NOISE = 3;
   localparam int CH_DELTA = 4;
   localparam int NUM_SOLO = 3;   // groups with a single channel: tri, noise, delta
endpackage

// File: rtl/decim_phase.sv
module decim_phase #(
   parameter int                PH_W    = 32,
   parameter logic [PH_W-1:0]   DEF_INC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PH_W-1:0] inc_in,
   input  logic            step,
   output logic            wrap
);
   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] inc_q;
   logic [PH_W:0]   sum_w;

   assign sum_w = {1'b0, phase_q} + {1'b0, inc_q};
   assign wrap  = step & sum_w[PH_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         inc_q   <= DEF_INC;
      end else if (load) begin
         phase_q <= '0;
         inc_q   <= inc_in;
      end else if (step) begin
         phase_q <= sum_w[PH_W-1:0];
      end
   end

   // R2
   phase_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> phase_q < $past(inc_q));
   // R7
   phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(phase_q));
endmodule

// File: rtl/decim_acc.sv
module decim_acc #(
   parameter int IN_W  = 8,
   parameter int SUM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             dump,
   input  logic             add,
   input  logic [IN_W-1:0]  val,
   output logic [SUM_W-1:0] sum_q,
   output logic [SUM_W-1:0] sum_nx
);
   if (SUM_W < IN_W) begin : g_bad_width
      $error("decim_acc: SUM_W must not be below IN_W");
   end

   assign sum_nx = sum_q + (add ? SUM_W'(val) : '0);

   always_ff @(posedge clk) begin
      if (!rst_n)           sum_q <= '0;
      else if (clr || dump) sum_q <= '0;
      else                  sum_q <= sum_nx;
   end
endmodule

// File: rtl/decim_out.sv
module decim_out #(
   parameter int LVL_W = 7,
   parameter int CNT_W = 16,
   localparam int SP_W = LVL_W + 1 + CNT_W,
   localparam int SO_W = LVL_W + CNT_W,
   localparam int NS   = decim_pkg::NUM_SOLO
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  emit,
   input  logic                  ready,
   input  logic [SP_W-1:0]       pulse_nx,
   input  logic [NS*SO_W-1:0]    solo_nx,
   input  logic [CNT_W-1:0]      cnt_nx,
   output logic                  valid,
   output logic [LVL_W:0]        avg_pulse,
   output logic [NS*LVL_W-1:0]   avg_solo
);
   logic [CNT_W-1:0]    den;
   logic [LVL_W:0]      pulse_d;
   logic [NS*LVL_W-1:0] solo_d;

   assign den     = (cnt_nx == '0) ? CNT_W'(1) : cnt_nx;
   assign pulse_d = (LVL_W+1)'(pulse_nx / SP_W'(den));

   for (genvar g = 0; g < NS; g++) begin : g_div
      assign solo_d[g*LVL_W +: LVL_W] =
         LVL_W'(solo_nx[g*SO_W +: SO_W] / SO_W'(den));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid     <= 1'b0;
         avg_pulse <= '0;
         avg_solo  <= '0;
      end else if (clr) begin
         valid <= 1'b0;
      end else if (emit && (!valid || ready)) begin
         valid     <= 1'b1;
         avg_pulse <= pulse_d;
         avg_solo  <= solo_d;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready && !clr) |=> valid && $stable(avg_pulse) && $stable(avg_solo));
   // R2
   out_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(emit));
endmodule

// File: rtl/audio_decim.sv
module audio_decim #(
   parameter int LVL_W    = 7,
   parameter int CNT_W    = 16,
   parameter int PH_W     = 32,
   parameter int OUT_RATE = 44100,
   parameter int IN_RATE  = 1789773,
   localparam int SP_W    = LVL_W + 1 + CNT_W,
   localparam int SO_W    = LVL_W + CNT_W,
   localparam int NS      = decim_pkg::NUM_SOLO,
   localparam int NC      = decim_pkg::NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [LVL_W-1:0]  lvl_p1,
   input  logic [LVL_W-1:0]  lvl_p2,
   input  logic [LVL_W-1:0]  lvl_tri,
   input  logic [LVL_W-1:0]  lvl_noise,
   input  logic [LVL_W-1:0]  lvl_delta,
   input  logic [4:0]        mute,
   input  logic              inc_load,
   input  logic [PH_W-1:0]   inc_value,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [LVL_W:0]    avg_pulse,
   output logic [LVL_W-1:0]  avg_tri,
   output logic [LVL_W-1:0]  avg_noise,
   output logic [LVL_W-1:0]  avg_delta
);
   import decim_pkg::*;

   localparam logic [63:0]     DEF_INC64 = ((64'd1 << PH_W) * 64'(OUT_RATE)) / 64'(IN_RATE);
   localparam logic [PH_W-1:0] DEF_INC   = DEF_INC64[PH_W-1:0];
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   if (LVL_W < 1 || CNT_W < 2 || PH_W < 8 || PH_W > 48) begin : g_bad_param
      $error("audio_decim: parameter out of range");
   end
   if (OUT_RATE <= 0 || IN_RATE <= OUT_RATE) begin : g_bad_rate
      $error("audio_decim: output rate must be positive and below input rate");
   end

   logic [LVL_W-1:0]   lv  [NC];
   logic [LVL_W-1:0]   lvm [NC];
   logic               step, wrap, acc_en;
   logic [CNT_W-1:0]   cnt_q, cnt_nx;
   logic [SP_W-1:0]    pul_q, pul_nx;
   logic [NS*SO_W-1:0] solo_nx;
   logic [NS*LVL_W-1:0] avg_solo;
   logic [LVL_W:0]     pul_in;

   assign lv[CH_P1]    = lvl_p1;
   assign lv[CH_P2]    = lvl_p2;
   assign lv[CH_TRI]   = lvl_tri;
   assign lv[CH_NOISE] = lvl_noise;
   assign lv[CH_DELTA] = lvl_delta;

   for (genvar c = 0; c < NC; c++) begin : g_mute
      assign lvm[c] = mute[c] ? '0 : lv[c];
   end

   assign step   = in_valid & ~inc_load;
   assign acc_en = step & (cnt_q != CNT_MAX);
   assign pul_in = {1'b0, lvm[CH_P1]} + {1'b0, lvm[CH_P2]};

   decim_phase #(.PH_W(PH_W), .DEF_INC(DEF_INC)) u_phase (
      .clk(clk), .rst_n(rst_n), .load(inc_load), .inc_in(inc_value),
      .step(step), .wrap(wrap));

   decim_acc #(.IN_W(1), .SUM_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(inc_load), .dump(wrap), .add(acc_en),
      .val(1'b1), .sum_q(cnt_q), .sum_nx(cnt_nx));

   decim_acc #(.IN_W(LVL_W+1), .SUM_W(SP_W)) u_pulse (
      .clk(clk), .rst_n(rst_n), .clr(inc_load), .dump(wrap), .add(acc_en),
      .val(pul_in), .sum_q(pul_q), .sum_nx(pul_nx));

   for (genvar g = 0; g < NS; g++) begin : g_solo
      logic [SO_W-1:0] s_q;
      decim_acc #(.IN_W(LVL_W), .SUM_W(SO_W)) u_acc (
         .clk(clk), .rst_n(rst_n), .clr(inc_load), .dump(wrap), .add(acc_en),
         .val(lvm[CH_TRI+g]), .sum_q(s_q), .sum_nx(solo_nx[g*SO_W +: SO_W]));

      // R5
      solo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
         wrap |=> s_q == '0);
   end

   decim_out #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_out (
      .clk(clk), .rst_n(rst_n), .clr(inc_load), .emit(wrap), .ready(out_ready),
      .pulse_nx(pul_nx), .solo_nx(solo_nx), .cnt_nx(cnt_nx),
      .valid(out_valid), .avg_pulse(avg_pulse), .avg_solo(avg_solo));

   assign avg_tri   = avg_solo[0*LVL_W +: LVL_W];
   assign avg_noise = avg_solo[1*LVL_W +: LVL_W];
   assign avg_delta = avg_solo[2*LVL_W +: LVL_W];

   // R9
   cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !wrap && !inc_load) |=> cnt_q == CNT_MAX && $stable(pul_q));
   // R8
   load_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc_load |=> !out_valid && cnt_q == '0);
   // R5
   pulse_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> pul_q == '0 && cnt_q == '0);
endmodule

// File: tb/audio_decim_test.sv
module audio_decim_test;
   localparam int  CLK_PERIOD = 10;
   localparam int  LVL_W = 7;
   localparam int  CNT_W = 6;
   localparam int  CMAX  = (1 << CNT_W) - 1;
   localparam longint TWO32 = 64'd1 << 32;
   localparam longint DEF_INC = (TWO32 * 44100) / 1789773;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [LVL_W-1:0] lvl_p1 = '0, lvl_p2 = '0, lvl_tri = '0, lvl_noise = '0, lvl_delta = '0;
   logic [4:0]  mute = '0;
   logic        inc_load = 1'b0;
   logic [31:0] inc_value = '0;
   logic        out_ready = 1'b0;
   logic        out_valid;
   logic [LVL_W:0]   avg_pulse;
   logic [LVL_W-1:0] avg_tri, avg_noise, avg_delta;

   int n_checks = 0;
   int n_fail = 0;
   string cur_req = "R1";

   // behavioural reference state
   longint m_phase, m_inc;
   int s_p, s_t, s_n, s_d, m_cnt;
   bit m_ov;
   int e_p, e_t, e_n, e_d;

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_decim #(.LVL_W(LVL_W), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .lvl_p1(lvl_p1), .lvl_p2(lvl_p2), .lvl_tri(lvl_tri),
      .lvl_noise(lvl_noise), .lvl_delta(lvl_delta), .mute(mute),
      .inc_load(inc_load), .inc_value(inc_value),
      .out_valid(out_valid), .out_ready(out_ready),
      .avg_pulse(avg_pulse), .avg_tri(avg_tri),
      .avg_noise(avg_noise), .avg_delta(avg_delta));

   task automatic chk(string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_phase = 0; m_inc = DEF_INC;
      s_p = 0; s_t = 0; s_n = 0; s_d = 0; m_cnt = 0;
      m_ov = 0; e_p = 0; e_t = 0; e_n = 0; e_d = 0;
   endtask

   task automatic compare();
      chk("out_valid", int'(out_valid), int'(m_ov));
      if (m_ov) begin
         chk("avg_pulse", int'(avg_pulse), e_p);
         chk("avg_tri",   int'(avg_tri),   e_t);
         chk("avg_noise", int'(avg_noise), e_n);
         chk("avg_delta", int'(avg_delta), e_d);
      end
   endtask

   // model of the clock edge that follows the current inputs
   task automatic model_edge();
      bit carry = 0;
      int c;
      if (inc_load) begin
         m_inc = longint'(inc_value);
         m_phase = 0; s_p = 0; s_t = 0; s_n = 0; s_d = 0; m_cnt = 0;
         m_ov = 0;
         return;
      end
      if (in_valid) begin
         if (m_cnt < CMAX) begin
            s_p += (mute[0] ? 0 : int'(lvl_p1)) + (mute[1] ? 0 : int'(lvl_p2));
            s_t += mute[2] ? 0 : int'(lvl_tri);
            s_n += mute[3] ? 0 : int'(lvl_noise);
            s_d += mute[4] ? 0 : int'(lvl_delta);
            m_cnt++;
         end
         m_phase += m_inc;
         if (m_phase >= TWO32) begin
            m_phase -= TWO32;
            carry = 1;
         end
      end
      if (carry && (!m_ov || out_ready)) begin
         c = (m_cnt < 1) ? 1 : m_cnt;
         e_p = s_p / c; e_t = s_t / c; e_n = s_n / c; e_d = s_d / c;
         m_ov = 1;
      end else if (out_ready) begin
         m_ov = 0;
      end
      if (carry) begin
         s_p = 0; s_t = 0; s_n = 0; s_d = 0; m_cnt = 0;
      end
   endtask

   task automatic step(bit v, bit rdy, logic [4:0] mk, bit ld, logic [31:0] incv);
      @(negedge clk);
      compare();
      in_valid  = v;
      out_ready = rdy;
      mute      = mk;
      inc_load  = ld;
      inc_value = incv;
      lvl_p1    = LVL_W'($urandom_range(0, 127));
      lvl_p2    = LVL_W'($urandom_range(0, 127));
      lvl_tri   = LVL_W'($urandom_range(0, 127));
      lvl_noise = LVL_W'($urandom_range(0, 127));
      lvl_delta = LVL_W'($urandom_range(0, 127));
      model_edge();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, then default increment governs first window
      cur_req = "R1";
      step(0, 1, 5'h00, 0, 0);
      step(0, 1, 5'h00, 0, 0);
      for (int i = 0; i < 100; i++) step(1, 1, 5'h00, 0, 0);
      // R2 R3 R4 R5: steady flow, ready always high
      cur_req = "R4";
      for (int i = 0; i < 400; i++) step(1, 1, 5'h00, 0, 0);
      // R6: mute patterns
      cur_req = "R6";
      for (int i = 0; i < 300; i++) step(1, 1, 5'($urandom_range(0, 31)), 0, 0);
      for (int i = 0; i < 100; i++) step(1, 1, 5'h1f, 0, 0);
      // R7: gaps in valid input
      cur_req = "R7";
      for (int i = 0; i < 400; i++) step(($urandom_range(0, 2) != 0), 1, 5'h00, 0, 0);
      // R10 R11: consumer stalls
      cur_req = "R10";
      for (int i = 0; i < 200; i++) step(1, 0, 5'h00, 0, 0);
      cur_req = "R11";
      for (int i = 0; i < 400; i++) step(1, ($urandom_range(0, 3) == 0), 5'h00, 0, 0);
      // R8: load new increment while a sample is held, valid input ignored
      cur_req = "R8";
      for (int i = 0; i < 60; i++) step(1, 0, 5'h00, 0, 0);
      step(1, 0, 5'h00, 1, 32'(TWO32 / 20));
      for (int i = 0; i < 200; i++) step(1, 1, 5'h00, 0, 0);
      // R9: window longer than the count range
      cur_req = "R9";
      step(0, 1, 5'h00, 1, 32'(TWO32 / 100));
      for (int i = 0; i < 500; i++) step(1, 1, 5'h00, 0, 0);
      // R2: back to the default rate
      cur_req = "R2";
      step(0, 1, 5'h00, 1, 32'(DEF_INC));
      for (int i = 0; i < 300; i++) step(1, 1, 5'h00, 0, 0);
      @(negedge clk);
      compare();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule